// File: doc/BRIEF.md
# Flash Status Register Unit

This block keeps the 8-bit status word of a command-driven flash memory model and places it on the 16-bit data pins when that word is read. Three bits report the live device state: ready, erase-suspended and program-suspended. The internal operation controller raises and lowers these bits with one-cycle set and clear pulses. Four error bits are sticky. A set pulse turns one on, and it then stays on until software writes a clear-status command. Bit 0 is reserved and is always 0.

Commands arrive as bus-write cycles. The low byte of the write is decoded as follows:

- 70h switches the read path to status mode.
- 50h clears the sticky error bits.

In status mode, a read access starts when both chip-enable and output-enable are low. At that moment the status word is copied into an output latch. The latch holds its value for the whole access, and it is loaded again only after one of the two strobes has gone high and the access starts over. When the captured ready bit shows busy, only bit 7 and the zero upper byte are driven. All other low bits are left undriven.

Top module: `flash_status_reg`

## Requirements
- R1: After reset the status word is 80h and status mode is off. With status mode off, no data pin is driven (all `dq_oe` bits 0), even during an access.
- R2: A bus-write whose low byte is 70h enables status mode. Each following access drives the status word on bits 7:0, 00h on bits 15:8, and enables all 16 pins (`dq_oe` = FFFFh) while the word shows ready.
- R3: Live bits 7 (ready, 1 = ready), 6 (erase suspended) and 2 (program suspended) are set by `set_i` and cleared by `clr_i`. When both pulses hit the same bit in one cycle, the set wins.
- R4: Error bits 5 (erase error), 4 (program error), 3 (voltage error) and 1 (block locked error) are set by `set_i`. A `clr_i` pulse has no effect on them. A new error is OR-ed into the bits already set.
- R5: A bus-write whose low byte is 50h clears bits 5, 4, 3 and 1. It leaves bits 7, 6 and 2 and status mode unchanged. A set pulse in the same cycle is kept.
- R6: The output latch loads the status word in the cycle where the later of the two strobes goes low. It holds that value while both strobes stay low, even if the status word changes.
- R7: After output-enable or chip-enable has gone high, the next access loads the current status word.
- R8: When the captured bit 7 is 0 (busy), bits 6:0 are not driven (`dq_oe` = FF80h). The pins then show bit 7 = 0 and the upper byte 00h.
- R9: Whenever chip-enable or output-enable is high, `dq_oe` is 0 from the next cycle on.
- R10: Bits 5:4 form a code: 00 = success, 01 = program error, 10 = erase error, 11 = command sequence error. Setting both gives 30h in the word. Bit 0 always reads 0, even when `set_i[0]` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Combined chip-enable, active low |
| oe_n | input | 1 | Output-enable, active low |
| we | input | 1 | One-cycle bus-write strobe |
| wdata | input | 16 | Bus-write data; the low byte holds the command code |
| set_i | input | 8 | Per-bit set pulses from the operation controller |
| clr_i | input | 8 | Per-bit clear pulses from the operation controller (live bits only) |
| dq_out | output | 16 | Data pin values |
| dq_oe | output | 16 | Per-pin output enable |

## Verification
A fault in the status word itself shows on the pins at the next access, one cycle after both strobes are low. This covers an error bit lost without a clear, a live bit stuck, or a clear that reaches the live bits. A fault in the latch shows only inside an access: a wrong hold lets the pins move in mid-access, and a failed re-arm shows a stale value after a strobe toggles. Faults in the busy mask or in the mode flag show as a wrong `dq_oe` pattern in the same sampled cycle. The stimulus therefore reads the word after every change and also changes the word during held accesses.

// File: rtl/flash_status_reg.sv
module flash_status_reg #(
  parameter logic [7:0] CMD_RD_STATUS = 8'h70,
  parameter logic [7:0] CMD_CLR_STATUS = 8'h50,
  parameter logic [7:0] RESET_WORD = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we,
  input  logic [15:0] wdata,
  input  logic [7:0]  set_i,
  input  logic [7:0]  clr_i,
  output logic [15:0] dq_out,
  output logic [15:0] dq_oe
);

  localparam logic [7:0] LIVE_M = 8'hC4;
  localparam logic [7:0] ERR_M  = 8'h3A;

  logic [7:0] sr, sr_nxt, lat;
  logic       stat_mode, acc_q;

  wire cmd_rd  = we && (wdata[7:0] == CMD_RD_STATUS);
  wire cmd_clr = we && (wdata[7:0] == CMD_CLR_STATUS);
  wire access  = !ce_n && !oe_n;
  wire drive   = acc_q && stat_mode;
  wire busy    = !lat[7];

  always_comb begin
    sr_nxt = ((sr & ~clr_i) | set_i) & LIVE_M;
    sr_nxt = sr_nxt | ((cmd_clr ? 8'h00 : (sr & ERR_M)) | (set_i & ERR_M));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr        <= RESET_WORD;
      stat_mode <= 1'b0;
      acc_q     <= 1'b0;
      lat       <= RESET_WORD;
    end else begin
      sr    <= sr_nxt;
      acc_q <= access;
      if (cmd_rd) stat_mode <= 1'b1;
      if (access && !acc_q) lat <= sr;
    end
  end

  assign dq_oe  = drive ? {8'hFF, 1'b1, busy ? 7'h00 : 7'h7F} : 16'h0000;
  assign dq_out = drive ? {8'h00, lat[7], busy ? 7'h00 : lat[6:0]} : 16'h0000;

  p_ready_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[7] |=> sr[7]);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_clr |=> ((sr & $past(sr) & ERR_M) == ($past(sr) & ERR_M)));

  p_clear_errs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && ((set_i & ERR_M) == 8'h00)) |=> ((sr & ERR_M) == 8'h00));

  p_clear_keeps_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && set_i == 8'h00 && clr_i == 8'h00) |=> (sr == ($past(sr) & LIVE_M)));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && access) |=> $stable(lat));

  p_busy_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[7] && !dq_out[7]) |-> (dq_oe[6:0] == 7'h00));

  p_idle_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> (dq_oe == 16'h0000));

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sr[0] == 1'b0));

endmodule

// File: tb/tb_flash_status_reg.sv
`timescale 1ns/1ps
module tb_flash_status_reg;
  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we = 0;
  logic [15:0] wdata = 0;
  logic [7:0]  set_i = 0, clr_i = 0;
  logic [15:0] dq_out, dq_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_status_reg dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we(we),
    .wdata(wdata), .set_i(set_i), .clr_i(clr_i), .dq_out(dq_out), .dq_oe(dq_oe));

  // fields: set, clr, cmd valid, cmd, expected pins, expected enables, requirement
  localparam logic [60:0] VEC [12] = '{
    {8'h00, 8'h00, 1'b1, 8'h70, 16'h0080, 16'hFFFF, 4'd2},  // R2
    {8'h40, 8'h00, 1'b0, 8'h00, 16'h00C0, 16'hFFFF, 4'd3},  // R3
    {8'h10, 8'h00, 1'b0, 8'h00, 16'h00D0, 16'hFFFF, 4'd4},  // R4
    {8'h00, 8'h10, 1'b0, 8'h00, 16'h00D0, 16'hFFFF, 4'd4},  // R4 clr ignored
    {8'h20, 8'h00, 1'b0, 8'h00, 16'h00F0, 16'hFFFF, 4'd10}, // R10 code 11
    {8'h03, 8'h00, 1'b0, 8'h00, 16'h00F2, 16'hFFFF, 4'd10}, // R10 bit0 stays 0
    {8'h04, 8'h40, 1'b0, 8'h00, 16'h00B6, 16'hFFFF, 4'd3},  // R3
    {8'h00, 8'h00, 1'b1, 8'h50, 16'h0084, 16'hFFFF, 4'd5},  // R5
    {8'h08, 8'h04, 1'b0, 8'h00, 16'h0088, 16'hFFFF, 4'd4},  // R4 OR-in
    {8'h00, 8'h80, 1'b0, 8'h00, 16'h0000, 16'hFF80, 4'd8},  // R8 busy
    {8'h80, 8'h80, 1'b0, 8'h00, 16'h0088, 16'hFFFF, 4'd3},  // R3 set wins
    {8'h00, 8'h00, 1'b1, 8'h50, 16'h0080, 16'hFFFF, 4'd5}   // R5
  };

  task automatic chk(input string req, input logic [15:0] eo, input logic [15:0] ee);
    total++;
    if (dq_out !== eo || dq_oe !== ee) begin
      bad++;
      $display("FAIL %s: dq_out=%h dq_oe=%h expected dq_out=%h dq_oe=%h", req, dq_out, dq_oe, eo, ee);
    end
  endtask

  task automatic pulse(input logic [7:0] s, input logic [7:0] c, input logic v, input logic [7:0] cmd);
    set_i = s; clr_i = c; we = v; wdata = {8'h00, cmd};
    @(negedge clk);
    set_i = 0; clr_i = 0; we = 0; wdata = 0;
  endtask

  task automatic rd(input string req, input logic [15:0] eo, input logic [15:0] ee);
    ce_n = 0; oe_n = 0;
    @(negedge clk);
    chk(req, eo, ee);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 idle", 16'h0000, 16'h0000);
    rd("R1 mode off", 16'h0000, 16'h0000);

    for (int i = 0; i < 12; i++) begin
      pulse(VEC[i][60:53], VEC[i][52:45], VEC[i][44], VEC[i][43:36]);
      rd($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][35:20], VEC[i][19:4]);
    end

    // R6: hold during access while word changes
    ce_n = 0; oe_n = 0; @(negedge clk);
    chk("R6 capture", 16'h0080, 16'hFFFF);
    pulse(8'h02, 8'h00, 1'b0, 8'h00);
    chk("R6 hold", 16'h0080, 16'hFFFF);
    // R9 and R7 via output-enable
    oe_n = 1; @(negedge clk);
    chk("R9 oe high", 16'h0000, 16'h0000);
    oe_n = 0; @(negedge clk);
    chk("R7 rearm oe", 16'h0082, 16'hFFFF);
    // R7 via chip-enable
    ce_n = 1; @(negedge clk);
    chk("R9 ce high", 16'h0000, 16'h0000);
    pulse(8'h20, 8'h00, 1'b0, 8'h00);
    ce_n = 0; @(negedge clk);
    chk("R7 rearm ce", 16'h00A2, 16'hFFFF);
    ce_n = 1; oe_n = 1; @(negedge clk);
    // R6 staggered strobes: capture when later strobe falls
    ce_n = 0;
    pulse(8'h00, 8'h00, 1'b1, 8'h50);
    chk("R9 ce only", 16'h0000, 16'h0000);
    oe_n = 0; @(negedge clk);
    chk("R6 staggered", 16'h0080, 16'hFFFF);
    ce_n = 1; oe_n = 1; @(negedge clk);

    // R1 reset restores default and leaves status mode
    pulse(8'h3A, 8'h84, 1'b0, 8'h00);
    do_reset();
    rd("R1 mode cleared", 16'h0000, 16'h0000);
    pulse(8'h00, 8'h00, 1'b1, 8'h70);
    rd("R1 reset word", 16'h0080, 16'hFFFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule